// File: doc/BRIEF.md
# Periodic Reload Interrupt Timer

This block is a down-counting interval timer that sits on a simple word-addressed register bus. Software programs a reload value, sets the enable bit, and the counter then steps down once per tick pulse. When a tick arrives while the counter holds one, the counter takes the reload value again and a sticky event flag is raised. The result is an interrupt that recurs every reload-value ticks until software turns the timer off.

The tick pulse comes from an internal divider that fires once every `TICK_DIV` system clocks. For example, a 50 MHz clock with the default divider gives a 1 MHz tick. Software acknowledges an event by writing any value to the status word. A software reset bit in the control word clears the control word, the reload value and the counter in one write. A compare word is kept for software and has no effect on counting.

Reads are registered. The data and a valid strobe appear on the cycle after the read request.

Top module: `prt_timer`

## Requirements
- R1: After the synchronous reset, every readable word reads 0 and `irq_o` is low.
- R2: Word offsets are as follows: 0 is control, 1 is status (event flag in bit 0, other bits 0), 2 is reload, 3 is compare and 4 is counter. Any other offset reads 0. Read data is presented on `bus_rdata_o`, with `bus_rvalid_o` high, in the cycle after the request. The control word reads back the last value written to it.
- R3: A write to offset 2 stores the value and loads it into the counter at the same edge, even while counting. Such a write takes priority over a reload event due at the same edge, and that event is not raised.
- R4: While control bit 0 (enable) is 1, the counter decrements once per tick, with one tick every `TICK_DIV` clocks. While enable is 0, the counter holds its value.
- R5: A tick that arrives with the counter at 1 reloads the counter from the reload word and sets the event flag. A reload value of N therefore raises one event every N ticks.
- R6: A reload value of 0 keeps the counter at 0 and never raises the event flag.
- R7: Any write to offset 1 clears the event flag, whatever the data. If an event occurs at the same edge, the flag stays set.
- R8: `irq_o` is high exactly when both the event flag and the enable bit are set.
- R9: A control write with bit 16 set clears the control word, the reload word and the counter, so counting stops. Bit 16 always reads back as 0.
- R10: The compare word can be read and written but does not change counting. Writes to offset 4 and to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Bus access request this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Word offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Level interrupt: event flag AND enable |

## Verification
The countdown is exercised with several reload values: 10, 4, 5 and 20. Each run is stopped after a chosen number of enabled cycles, and the counter value that remains identifies the number of decrements and the position within the period. Watching the interrupt at the cycles just before and just after the expected event checks that the period is exact rather than off by one. Edge-aligned collisions are also tested: an acknowledge in the same cycle as an event, and a reload write in the same cycle as the counter reaching one. These two cases separate the intended priorities from the reversed ones. A zero reload value and a software reset issued while the timer is running each show that the counter stays still.

// File: rtl/prt_pkg.sv
package prt_pkg;

  // Control and status bit positions; software decodes these.
  localparam int unsigned EN_POS   = 0;
  localparam int unsigned SRST_POS = 16;
  localparam int unsigned FLAG_POS = 0;

  // Word offsets of the register window.
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_LOAD = 2;
  localparam int unsigned OFS_CMP  = 3;
  localparam int unsigned OFS_CNT  = 4;

  typedef struct packed {
    logic ctrl_wr;
    logic stat_wr;
    logic load_wr;
    logic cmp_wr;
    logic rd;
  } prt_strobe_t;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_LOAD,
    SEL_CMP,
    SEL_CNT,
    SEL_NONE
  } prt_rsel_e;

endpackage

// File: rtl/prt_tick_gen.sv
module prt_tick_gen #(
  parameter int unsigned TICK_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      if (div_q == LAST) div_q <= '0;
      else               div_q <= div_q + 1'b1;
      tick_q <= (div_q == LAST);
    end
  end

  assign tick_o = tick_q;

  generate
    if (TICK_DIV > 1) begin : g_spaced
      // R4: pulses are isolated when the divider is above one
      p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/prt_bus_dec.sv
module prt_bus_dec
  import prt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output prt_strobe_t       stb_o,
  output prt_rsel_e         rsel_o
);

  always_comb begin
    rsel_o = SEL_NONE;
    if      (addr_i == ADDR_W'(OFS_CTRL)) rsel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFS_STAT)) rsel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFS_LOAD)) rsel_o = SEL_LOAD;
    else if (addr_i == ADDR_W'(OFS_CMP))  rsel_o = SEL_CMP;
    else if (addr_i == ADDR_W'(OFS_CNT))  rsel_o = SEL_CNT;
  end

  always_comb begin
    stb_o.ctrl_wr = sel_i & wr_i & (rsel_o == SEL_CTRL);
    stb_o.stat_wr = sel_i & wr_i & (rsel_o == SEL_STAT);
    stb_o.load_wr = sel_i & wr_i & (rsel_o == SEL_LOAD);
    stb_o.cmp_wr  = sel_i & wr_i & (rsel_o == SEL_CMP);
    stb_o.rd      = sel_i & ~wr_i;
  end

endmodule

// File: rtl/prt_countdown.sv
module prt_countdown #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              run_en_i,
  input  logic              srst_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] load_o,
  output logic              evt_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] load_q;
  logic              step;

  assign step  = run_en_i & tick_i;
  // A reload write or a soft reset at the same edge takes priority over the event.
  assign evt_o = step & (cnt_q == ONE) & ~load_wr_i & ~srst_i;

  always_ff @(posedge clk) begin
    if (rst || srst_i) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else if (load_wr_i) begin
      load_q <= load_val_i;
      cnt_q  <= load_val_i;
    end else if (step) begin
      if (cnt_q == ONE)     cnt_q <= load_q;
      else if (cnt_q != '0) cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;

  // R4: without a tick under enable, the count does not move
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!step && !load_wr_i && !srst_i) |=> $stable(cnt_q));

  // R3: a reload write lands in the counter at once
  p_load_now_r3: assert property (@(posedge clk) disable iff (rst)
    (load_wr_i && !srst_i) |=> (cnt_q == $past(load_val_i)));

  // R5: an event is followed by the reload value
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> (cnt_q == $past(load_q)));

  // R6: a zero reload keeps the counter parked
  p_zero_park_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && load_q == '0 && !load_wr_i) |=> (cnt_q == '0));

endmodule

// File: rtl/prt_timer.sv
module prt_timer
  import prt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic              irq_o
);

  prt_strobe_t       stb;
  prt_rsel_e         rsel;
  logic              tick;
  logic              srst;
  logic              evt;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] load;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] cmp_q;
  logic              flag_q, flag_d;
  logic              irq_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  prt_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i  (bus_sel_i),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .stb_o  (stb),
    .rsel_o (rsel)
  );

  prt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  assign srst = stb.ctrl_wr & bus_wdata_i[SRST_POS];

  prt_countdown #(.DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .run_en_i   (ctrl_q[EN_POS]),
    .srst_i     (srst),
    .load_wr_i  (stb.load_wr),
    .load_val_i (bus_wdata_i),
    .cnt_o      (cnt),
    .load_o     (load),
    .evt_o      (evt)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (stb.ctrl_wr) ctrl_d = srst ? '0 : bus_wdata_i;
  end

  // A new event beats an acknowledge at the same edge.
  always_comb begin
    flag_d = flag_q;
    if (evt)              flag_d = 1'b1;
    else if (stb.stat_wr) flag_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & ctrl_d[EN_POS];
      if (stb.cmp_wr) cmp_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= stb.rd;
      if (stb.rd) begin
        unique case (rsel)
          SEL_CTRL: rdata_q <= ctrl_q;
          SEL_STAT: rdata_q <= DATA_W'({flag_q} << FLAG_POS);
          SEL_LOAD: rdata_q <= load;
          SEL_CMP:  rdata_q <= cmp_q;
          SEL_CNT:  rdata_q <= cnt;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign irq_o        = irq_q;

  // R2: every read request is answered on the next cycle
  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    stb.rd |=> bus_rvalid_o);

  // R2: unmapped offsets return zero
  p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    (stb.rd && rsel == SEL_NONE) |=> (bus_rdata_o == '0));

  // R7: an acknowledge with no event leaves the flag clear
  p_ack_r7: assert property (@(posedge clk) disable iff (rst)
    (stb.stat_wr && !evt) |=> !flag_q);

  // R7: an event always leaves the flag set
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag_q);

  // R8: the interrupt is the flag gated by enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_q && ctrl_q[EN_POS]));
  p_irq_due_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ctrl_q[EN_POS]) |-> irq_o);

  // R9: soft reset empties control and counter
  p_srst_r9: assert property (@(posedge clk) disable iff (rst)
    srst |=> (ctrl_q == '0 && cnt == '0 && load == '0));

endmodule

// File: tb/sim_prt_timer.sv
module sim_prt_timer;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic          wr  = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prt_timer #(.DATA_W(DW), .ADDR_W(AW), .TICK_DIV(1)) u0 (
    .clk          (clk),
    .rst          (rst),
    .bus_sel_i    (sel),
    .bus_wr_i     (wr),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .bus_rvalid_o (rvalid),
    .irq_o        (irq)
  );

  // Monitor: pops the expected word when the design presents read data.
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2 unexpected read data: got %h expected none", rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  // All tasks are entered at a falling edge; the access lands on the next rising edge.
  task automatic bus_write(input int a, input logic [DW-1:0] d);
    sel = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input int a, input logic [DW-1:0] e, input string t);
    sel = 1'b1; wr = 1'b0; addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string t);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, irq, e);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    bus_read(0, 32'h0, "R1 control after reset");
    bus_read(1, 32'h0, "R1 status after reset");
    bus_read(2, 32'h0, "R1 reload after reset");
    bus_read(3, 32'h0, "R1 compare after reset");
    bus_read(4, 32'h0, "R1 counter after reset");
    // R2 unmapped offsets
    bus_read(5, 32'h0, "R2 offset 5 reads zero");
    bus_read(15, 32'h0, "R2 offset 15 reads zero");

    // R3 reload write seeds the counter
    bus_write(2, 32'd10);
    bus_read(2, 32'd10, "R3 reload readback");
    bus_read(4, 32'd10, "R3 counter after reload write");

    // R10 compare and ignored writes
    bus_write(3, 32'hA5A5_0003);
    bus_read(3, 32'hA5A5_0003, "R10 compare readback");
    bus_write(4, 32'h0000_1234);
    bus_write(6, 32'hFFFF_FFFF);
    bus_read(4, 32'd10, "R10 counter unchanged by compare and offset-4 write");
    bus_read(6, 32'h0, "R10 unmapped write has no effect");

    // R4 countdown: 4 enabled edges, then hold
    bus_write(0, 32'h1);
    idle(3);
    bus_write(0, 32'h0);
    bus_read(4, 32'd6, "R4 counter after four ticks");
    idle(5);
    bus_read(4, 32'd6, "R4 counter holds while disabled");
    bus_read(1, 32'h0, "R4 no event yet");

    // R5 wrap: 8 more ticks from 6 passes one event, lands on 8
    bus_write(0, 32'h1);
    idle(7);
    bus_write(0, 32'h0);
    check_irq(1'b0, "R8 irq low while disabled with flag set");
    bus_read(1, 32'h1, "R5 event flag after wrap");
    bus_read(4, 32'd8, "R5 counter after reload");
    bus_write(0, 32'h1);
    check_irq(1'b1, "R8 irq high when enabled with flag set");
    bus_write(1, 32'h0);
    check_irq(1'b0, "R7 irq drops after zero-data acknowledge");
    bus_write(0, 32'h0);
    bus_read(1, 32'h0, "R7 flag cleared");
    bus_read(4, 32'd6, "R4 counter after two more ticks");

    // R5 exact period with reload 4
    bus_write(2, 32'd4);
    bus_write(0, 32'h1);
    idle(3);
    check_irq(1'b0, "R5 no event one tick early");
    idle(1);
    check_irq(1'b1, "R5 event after four ticks");
    bus_write(1, 32'hDEAD_BEEF);
    check_irq(1'b0, "R7 acknowledge with arbitrary data");
    idle(2);
    check_irq(1'b0, "R5 second period not yet due");
    idle(1);
    check_irq(1'b1, "R5 second event after four more ticks");
    bus_write(0, 32'h0);
    bus_read(4, 32'd3, "R5 counter position after nine ticks");

    // R3 reload while counting; collides with counter reaching one
    bus_write(1, 32'h0);
    bus_write(0, 32'h1);
    idle(2);
    bus_write(2, 32'd20);
    idle(4);
    bus_write(0, 32'h0);
    bus_read(2, 32'd20, "R3 reload value while counting");
    bus_read(4, 32'd15, "R3 countdown restarted from new value");
    bus_read(1, 32'h0, "R3 reload write suppresses due event");

    // R7 acknowledge in the same edge as an event: flag stays
    bus_write(2, 32'd5);
    bus_write(1, 32'h0);
    bus_write(0, 32'h1);
    idle(4);
    bus_write(1, 32'h1);
    bus_write(0, 32'h0);
    bus_read(1, 32'h1, "R7 event wins over same-edge acknowledge");
    bus_read(4, 32'd4, "R5 counter after reload and one tick");

    // R6 zero reload
    bus_write(2, 32'd0);
    bus_write(1, 32'h0);
    bus_write(0, 32'h1);
    idle(20);
    check_irq(1'b0, "R6 no interrupt with zero reload");
    bus_write(0, 32'h0);
    bus_read(4, 32'h0, "R6 counter parked at zero");
    bus_read(1, 32'h0, "R6 no event with zero reload");

    // R9 soft reset while running
    bus_write(2, 32'd9);
    bus_write(0, 32'h1);
    idle(2);
    bus_write(0, 32'h0001_0001);
    bus_read(0, 32'h0, "R9 control cleared by soft reset");
    bus_read(2, 32'h0, "R9 reload cleared by soft reset");
    bus_read(4, 32'h0, "R9 counter cleared by soft reset");
    bus_write(2, 32'd7);
    idle(3);
    bus_read(4, 32'd7, "R9 counting stopped after soft reset");

    // R2 control readback
    bus_write(0, 32'h0000_0300);
    bus_read(0, 32'h0000_0300, "R2 control readback");
    idle(3);
    bus_read(4, 32'd7, "R4 enable clear in stored control holds counter");

    idle(3);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 missing read data: got %0d pending expected 0", exp_q.size());
    end
    summary();
  end

endmodule